// File: doc/BRIEF.md
# Idle and Stop Power-Mode Controller

This block sequences the low-power states of a small microcontroller core. Software asks for a lower-power state by writing a one-cycle strobe carrying two mode bits. One bit requests a light sleep, called IDLE. The other requests a deep sleep, called STOP. The block then drives three enables: the CPU clock enable, the peripheral clock enable and the voltage-reference enable. It also reports its current state.

In IDLE only the CPU clock is gated. Timers and serial logic keep running, so any interrupt can wake the core. In STOP every internal clock is gated, and only an external interrupt brings the core back. A configuration input, `ref_in_stop_i`, chooses whether the voltage reference stays powered in STOP. When it does, a power-fail interrupt or a power-fail reset detection also wakes the block. The mode bits are held inside the block and clear when it returns to RUN.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first request, `state_o` is RUN (2'b00) and `cpu_clk_en_o`, `per_clk_en_o` and `ref_en_o` are all 1.
- R2: A write with `wdata_i[0]`=1 and `wdata_i[1]`=0 moves the state to IDLE (2'b01) at the next clock edge.
- R3: In IDLE, `cpu_clk_en_o`=0, `per_clk_en_o`=1 and `ref_en_o`=1.
- R4: A write with `wdata_i[1]`=1 moves the state to STOP (2'b10) at the next clock edge. This holds whatever the value of `wdata_i[0]`, so STOP wins over IDLE.
- R5: In STOP, both clock enables are 0 and `ref_en_o` equals `ref_in_stop_i`.
- R6: In IDLE, a high level on `ext_irq_i`, on any bit of `per_irq_i`, or on `pf_irq_i` returns the state to RUN at the next edge.
- R7: In STOP, `per_irq_i` has no effect, and neither does `pf_irq_i` or `pf_rst_i` when `ref_in_stop_i`=0. The state stays STOP.
- R8: In STOP, `ext_irq_i` returns the state to RUN at the next edge. So does `pf_irq_i` or `pf_rst_i` when `ref_in_stop_i`=1.
- R9: The stored mode bits `mode_bits_o` (bit 0 = IDLE request, bit 1 = STOP request) are set by the write that starts a sleep and read 2'b00 in every cycle the state is RUN.
- R10: Asserting `pf_rst_i` while in RUN or IDLE returns the block to RUN with all enables 1 at the next edge.
- R11: A write while in IDLE or STOP is ignored: the state and the mode bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Strobe that writes the mode bits |
| wdata_i | input | 2 | Mode bits to write: bit 1 requests STOP, bit 0 requests IDLE |
| ext_irq_i | input | 1 | External interrupt, level |
| per_irq_i | input | NUM_PER_IRQ | Peripheral interrupts, level |
| ref_in_stop_i | input | 1 | Keep the voltage reference on during STOP |
| pf_irq_i | input | 1 | Power-fail interrupt detection |
| pf_rst_i | input | 1 | Power-fail reset detection |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| ref_en_o | output | 1 | Voltage reference enable |
| state_o | output | 2 | Current state: 00 RUN, 01 IDLE, 10 STOP |
| mode_bits_o | output | 2 | Stored mode bits |

## Verification
The assertions assume that every input is synchronous to `clk_i`. They also assume that `ref_in_stop_i` does not change while the block is in STOP, because the wake check for STOP compares against its current value. The bench changes inputs only on falling edges and sets the reference option before it issues each STOP write. Wake sources are pulsed for exactly one cycle, so each transition can be tied to a single edge.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_IDLE = 2'b01,
    ST_STOP = 2'b10
  } pwr_state_e;

  localparam int unsigned MODE_W   = 2;
  localparam int unsigned IDLE_BIT = 0;
  localparam int unsigned STOP_BIT = 1;
endpackage

// File: rtl/pwr_wake_logic.sv
module pwr_wake_logic
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_PER_IRQ = 4
) (
  input  logic                   ext_irq_i,
  input  logic [NUM_PER_IRQ-1:0] per_irq_i,
  input  logic                   ref_in_stop_i,
  input  logic                   pf_irq_i,
  input  logic                   pf_rst_i,
  output logic                   idle_wake_o,
  output logic                   stop_wake_o
);
  logic any_per;
  logic pf_any;

  assign any_per = |per_irq_i;
  assign pf_any  = pf_irq_i | pf_rst_i;

  assign idle_wake_o = ext_irq_i | any_per | pf_any;
  // power-fail only counts in STOP when the reference is kept alive
  assign stop_wake_o = ext_irq_i | (ref_in_stop_i & pf_any);
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  input  logic              idle_wake_i,
  input  logic              stop_wake_i,
  input  logic              pf_rst_i,
  output pwr_state_e        state_o,
  output logic [MODE_W-1:0] mode_o
);
  pwr_state_e state_q, state_d;
  logic [MODE_W-1:0] mode_q, mode_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    unique case (state_q)
      ST_RUN: begin
        if (pf_rst_i) begin
          state_d = ST_RUN;
          mode_d  = '0;
        end else if (we_i && wdata_i[STOP_BIT]) begin
          state_d = ST_STOP;
          mode_d  = wdata_i;
        end else if (we_i && wdata_i[IDLE_BIT]) begin
          state_d = ST_IDLE;
          mode_d  = wdata_i;
        end
      end
      ST_IDLE: if (idle_wake_i) begin
        state_d = ST_RUN;
        mode_d  = '0;
      end
      ST_STOP: if (stop_wake_i) begin
        state_d = ST_RUN;
        mode_d  = '0;
      end
      default: begin
        state_d = ST_RUN;
        mode_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      mode_q  <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;

  AST_RUN_MODE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN |-> mode_q == '0) else $error("mode bits set in RUN"); // R9
  AST_STOP_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !pf_rst_i && we_i && wdata_i[STOP_BIT]) |=> state_q == ST_STOP)
    else $error("stop not taken"); // R4
  AST_IDLE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !pf_rst_i && we_i && wdata_i == 2'b01) |=> state_q == ST_IDLE)
    else $error("idle not taken"); // R2
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && !stop_wake_i) |=> state_q == ST_STOP) else $error("stop left"); // R7
  AST_SLEEP_WRITE_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN && we_i && !idle_wake_i && !stop_wake_i) |=> $stable(mode_q))
    else $error("write in sleep"); // R11
  AST_PF_RST_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_STOP && pf_rst_i) |=> state_q == ST_RUN) else $error("pf reset"); // R10
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_PER_IRQ = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [1:0]             wdata_i,
  input  logic                   ext_irq_i,
  input  logic [NUM_PER_IRQ-1:0] per_irq_i,
  input  logic                   ref_in_stop_i,
  input  logic                   pf_irq_i,
  input  logic                   pf_rst_i,
  output logic                   cpu_clk_en_o,
  output logic                   per_clk_en_o,
  output logic                   ref_en_o,
  output logic [1:0]             state_o,
  output logic [1:0]             mode_bits_o
);
  logic       idle_wake, stop_wake;
  pwr_state_e state;

  pwr_wake_logic #(.NUM_PER_IRQ(NUM_PER_IRQ)) u_wake (
    .ext_irq_i    (ext_irq_i),
    .per_irq_i    (per_irq_i),
    .ref_in_stop_i(ref_in_stop_i),
    .pf_irq_i     (pf_irq_i),
    .pf_rst_i     (pf_rst_i),
    .idle_wake_o  (idle_wake),
    .stop_wake_o  (stop_wake)
  );

  pwr_state_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .idle_wake_i(idle_wake),
    .stop_wake_i(stop_wake),
    .pf_rst_i   (pf_rst_i),
    .state_o    (state),
    .mode_o     (mode_bits_o)
  );

  always_comb begin
    cpu_clk_en_o = 1'b1;
    per_clk_en_o = 1'b1;
    ref_en_o     = 1'b1;
    unique case (state)
      ST_IDLE: cpu_clk_en_o = 1'b0;
      ST_STOP: begin
        cpu_clk_en_o = 1'b0;
        per_clk_en_o = 1'b0;
        ref_en_o     = ref_in_stop_i;
      end
      default: ;
    endcase
  end

  assign state_o = state;

  AST_IDLE_CLKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b01 |-> (!cpu_clk_en_o && per_clk_en_o && ref_en_o)) else $error("idle clks"); // R3
  AST_STOP_CLKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b10 |-> (!cpu_clk_en_o && !per_clk_en_o && ref_en_o == ref_in_stop_i))
    else $error("stop clks"); // R5
  AST_RUN_CLKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b00 |-> (cpu_clk_en_o && per_clk_en_o && ref_en_o)) else $error("run clks"); // R1
  AST_IDLE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01 && (ext_irq_i || (|per_irq_i) || pf_irq_i)) |=> state_o == 2'b00)
    else $error("idle wake"); // R6
  AST_STOP_EXT_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10 && ext_irq_i) |=> state_o == 2'b00) else $error("stop wake"); // R8
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPI = 4;

  logic clk = 0, rst_n = 0, we = 0;
  logic [1:0] wdata = 0;
  logic ext_irq = 0, ref_stop = 0, pf_irq = 0, pf_rst = 0;
  logic [NPI-1:0] per_irq = 0;
  logic cpu_en, per_en, ref_en;
  logic [1:0] state, mode;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.NUM_PER_IRQ(NPI)) u_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .wdata_i(wdata), .ext_irq_i(ext_irq),
    .per_irq_i(per_irq), .ref_in_stop_i(ref_stop), .pf_irq_i(pf_irq), .pf_rst_i(pf_rst),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .ref_en_o(ref_en),
    .state_o(state), .mode_bits_o(mode)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // checks state, enables {cpu,per,ref}, mode
  task automatic chk_all(string req, logic [1:0] s, logic [2:0] en, logic [1:0] m);
    chk(req, {6'd0, state}, {6'd0, s});
    chk(req, {5'd0, cpu_en, per_en, ref_en}, {5'd0, en});
    chk(req, {6'd0, mode}, {6'd0, m});
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(logic [1:0] d);
    we = 1; wdata = d; cyc(); we = 0; wdata = 0;
  endtask

  task automatic t_reset();
    chk_all("R1", 2'b00, 3'b111, 2'b00);
    rst_n = 1; cyc(); cyc();
    chk_all("R1", 2'b00, 3'b111, 2'b00);
  endtask

  task automatic t_idle();
    wr(2'b01);
    chk_all("R2/R3/R9", 2'b01, 3'b011, 2'b01);
    wr(2'b10);
    chk_all("R11", 2'b01, 3'b011, 2'b01);
    per_irq = 4'b0100; cyc(); per_irq = 0;
    chk_all("R6/R9", 2'b00, 3'b111, 2'b00);
    wr(2'b01); ext_irq = 1; cyc(); ext_irq = 0;
    chk_all("R6", 2'b00, 3'b111, 2'b00);
    wr(2'b01); pf_irq = 1; cyc(); pf_irq = 0;
    chk_all("R6", 2'b00, 3'b111, 2'b00);
  endtask

  task automatic t_stop_noref();
    ref_stop = 0;
    wr(2'b11);
    chk_all("R4/R5", 2'b10, 3'b000, 2'b11);
    per_irq = 4'b1111; pf_irq = 1; cyc(); per_irq = 0; pf_irq = 0;
    chk_all("R7", 2'b10, 3'b000, 2'b11);
    pf_rst = 1; cyc(); pf_rst = 0;
    chk_all("R7", 2'b10, 3'b000, 2'b11);
    wr(2'b01);
    chk_all("R11", 2'b10, 3'b000, 2'b11);
    ext_irq = 1; cyc(); ext_irq = 0;
    chk_all("R8/R9", 2'b00, 3'b111, 2'b00);
  endtask

  task automatic t_stop_ref();
    ref_stop = 1;
    wr(2'b10);
    chk_all("R5", 2'b10, 3'b001, 2'b10);
    per_irq = 4'b0001; cyc(); per_irq = 0;
    chk_all("R7", 2'b10, 3'b001, 2'b10);
    pf_irq = 1; cyc(); pf_irq = 0;
    chk_all("R8", 2'b00, 3'b111, 2'b00);
    wr(2'b10); pf_rst = 1; cyc(); pf_rst = 0;
    chk_all("R8", 2'b00, 3'b111, 2'b00);
    ref_stop = 0;
  endtask

  task automatic t_pf_rst();
    we = 1; wdata = 2'b01; pf_rst = 1; cyc(); we = 0; wdata = 0; pf_rst = 0;
    chk_all("R10", 2'b00, 3'b111, 2'b00);
    wr(2'b01); pf_rst = 1; cyc(); pf_rst = 0;
    chk_all("R10", 2'b00, 3'b111, 2'b00);
    wr(2'b10); rst_n = 0; #1;
    chk_all("R1", 2'b00, 3'b111, 2'b00);
    cyc(); rst_n = 1; cyc();
  endtask

  initial begin
    cyc();
    t_reset();
    t_idle();
    t_stop_noref();
    t_stop_ref();
    t_pf_rst();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule